// File: doc/BRIEF.md
# Priority-Level Interrupt Selector

This block decides, every clock, whether one of four pending hardware interrupt requests should be taken and, if so, which one. The four request classes are a device request, a periodic timer request, a request from a peer processor and a machine-check request. Whether a class may get through depends on the processor's 3-bit interrupt priority level. A privileged-mode flag blocks every class outright.

The choice among eligible requests is made combinationally in a fixed order of urgency. The result is registered, so a take strobe, a cause code and an all-zero error code appear one clock after the inputs that produced them. These outputs drive the exception entry logic directly. Raising, acknowledging and clearing requests is left to the surrounding logic: a request that stays asserted is taken again on every cycle in which it is eligible.

Top module: `irq_level_picker`

## Requirements
- R1: After reset, and until the first eligible request has been registered, `take` is 0, `cause` is 0 and `errCode` is 0.
- R2: If `privMode` is 1 at a clock edge, `take` is 0 after that edge, whatever the requests and the level.
- R3: At priority levels 0, 1, 2 and 3, all four classes are eligible. A device request on its own is taken with cause 4.
- R4: At level 4 the device class is ignored (a lone device request gives `take` = 0). Timer, peer and machine-check requests are still eligible.
- R5: At level 5 only peer and machine-check requests are eligible. A lone timer or device request gives `take` = 0.
- R6: At level 6 only a machine-check request is eligible.
- R7: At level 7 no request is taken.
- R8: When several eligible requests are present, the winner is chosen in this order: machine check first, then peer, then timer, then device.
- R9: The cause codes are machine check = 1, peer = 2, timer = 3 and device = 4. When `take` is 0, `cause` is 0.
- R10: Whenever `take` is 1, `errCode` is 0.
- R11: `take`, `cause` and `errCode` are registered. They reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqDevice | input | 1 | Pending device interrupt |
| reqTimer | input | 1 | Pending timer interrupt |
| reqPeer | input | 1 | Pending interprocessor interrupt |
| reqMachine | input | 1 | Pending machine-check interrupt |
| ipl | input | 3 | Current interrupt priority level |
| privMode | input | 1 | Privileged-mode flag; 1 blocks all interrupts |
| take | output | 1 | An interrupt is taken this cycle |
| cause | output | 3 | Code of the selected class; 0 when nothing is taken |
| errCode | output | 8 | Error code that accompanies the take; always zero |

## Verification
The failures that matter are a wrong eligibility threshold or a wrong pick. Either one shows up as a wrong `take` or `cause` exactly one clock after the offending input pattern, because there is no other state. A stuck or late output register shows up as a one-cycle skew against the reference model. The bench sweeps every combination of request, level and mode, and each combination is compared on the following edge, so a single bad table entry cannot hide.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;
  localparam int NUM_CLASS = 4;
  localparam int CAUSE_W   = 3;
  localparam int LEVEL_W   = 3;

  // class index: 0 device, 1 timer, 2 peer, 3 machine check
  // cause code is NUM_CLASS - index, so higher index = higher urgency
  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_MACHINE = 3'd1,
    CAUSE_PEER    = 3'd2,
    CAUSE_TIMER   = 3'd3,
    CAUSE_DEVICE  = 3'd4
  } cause_e;

  typedef struct packed {
    logic [NUM_CLASS-1:0] passMask;  // per-class eligibility
    logic                 anyOpen;   // at least one class can pass
  } gate_s;
endpackage

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_level_pkg::*;
#(
  parameter int DEV_MAX_LVL  = 3,
  parameter int TMR_MAX_LVL  = 4,
  parameter int PEER_MAX_LVL = 5,
  parameter int MCHK_MAX_LVL = 6
) (
  input  logic [LEVEL_W-1:0] ipl,
  input  logic               privMode,
  output gate_s              gate
);
  localparam int MAX_LVL [NUM_CLASS] = '{DEV_MAX_LVL, TMR_MAX_LVL, PEER_MAX_LVL, MCHK_MAX_LVL};

  logic [NUM_CLASS-1:0] passMask;

  for (genvar g = 0; g < NUM_CLASS; g++) begin : g_class
    assign passMask[g] = !privMode && (int'(ipl) <= MAX_LVL[g]);
  end

  always_comb begin
    gate.passMask = passMask;
    gate.anyOpen  = |passMask;
  end
endmodule

// File: rtl/irq_pick_dp.sv
module irq_pick_dp
  import irq_level_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CLASS-1:0] reqVec,
  input  gate_s                gate,
  output logic                 take,
  output logic [CAUSE_W-1:0]   cause,
  output logic [ERR_W-1:0]     errCode
);
  logic [NUM_CLASS-1:0] eligible;
  logic [CAUSE_W-1:0]   pickCause;
  logic                 pickAny;

  always_comb begin
    eligible  = reqVec & (gate.anyOpen ? gate.passMask : '0);
    pickAny   = |eligible;
    pickCause = CAUSE_NONE;
    for (int i = 0; i < NUM_CLASS; i++) begin
      if (eligible[i]) pickCause = CAUSE_W'(NUM_CLASS - i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      take    <= 1'b0;
      cause   <= CAUSE_NONE;
      errCode <= '0;
    end else begin
      take    <= pickAny;
      cause   <= pickCause;
      errCode <= '0;
    end
  end
endmodule

// File: rtl/irq_level_picker.sv
module irq_level_picker
  import irq_level_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqDevice,
  input  logic               reqTimer,
  input  logic               reqPeer,
  input  logic               reqMachine,
  input  logic [LEVEL_W-1:0] ipl,
  input  logic               privMode,
  output logic               take,
  output logic [CAUSE_W-1:0] cause,
  output logic [ERR_W-1:0]   errCode
);
  gate_s                gate;
  logic [NUM_CLASS-1:0] reqVec;

  assign reqVec = {reqMachine, reqPeer, reqTimer, reqDevice};

  irq_gate_ctrl u_ctrl (
    .ipl      (ipl),
    .privMode (privMode),
    .gate     (gate)
  );

  irq_pick_dp #(.ERR_W(ERR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .reqVec  (reqVec),
    .gate    (gate),
    .take    (take),
    .cause   (cause),
    .errCode (errCode)
  );
endmodule

// File: rtl/irq_level_chk.sv
module irq_level_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqDevice,
  input logic       reqMachine,
  input logic [2:0] ipl,
  input logic       privMode,
  input logic       take,
  input logic [2:0] cause
);
  a_r2_priv_blocks: assert property (@(posedge clk) disable iff (!rstN)
    privMode |=> !take);
  a_r7_top_level_closed: assert property (@(posedge clk) disable iff (!rstN)
    (ipl == 3'd7) |=> !take);
  a_r6_only_machine: assert property (@(posedge clk) disable iff (!rstN)
    (ipl == 3'd6 && !reqMachine) |=> !take);
  a_r8_machine_wins: assert property (@(posedge clk) disable iff (!rstN)
    (!privMode && ipl != 3'd7 && reqMachine) |=> (take && cause == 3'd1));
  a_r3_device_low_level: assert property (@(posedge clk) disable iff (!rstN)
    (!privMode && ipl <= 3'd3 && reqDevice) |=> take);
  a_r9_idle_cause: assert property (@(posedge clk) disable iff (!rstN)
    !take |-> (cause == 3'd0));
endmodule

bind irq_level_picker irq_level_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqDevice  (reqDevice),
  .reqMachine (reqMachine),
  .ipl        (ipl),
  .privMode   (privMode),
  .take       (take),
  .cause      (cause)
);

// File: tb/irq_level_picker_bench.sv
`timescale 1ns/1ps
module irq_level_picker_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqDevice = 0, reqTimer = 0, reqPeer = 0, reqMachine = 0;
  logic [2:0] ipl = 3'd0;
  logic       privMode = 1'b0;
  logic       take;
  logic [2:0] cause;
  logic [7:0] errCode;

  int total = 0;
  int bad = 0;
  int expCause = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  irq_level_picker u_irq_level_picker (
    .clk(clk), .rstN(rstN), .reqDevice(reqDevice), .reqTimer(reqTimer),
    .reqPeer(reqPeer), .reqMachine(reqMachine), .ipl(ipl),
    .privMode(privMode), .take(take), .cause(cause), .errCode(errCode)
  );

  // Reference: highest-urgency eligible class by level ceiling
  function automatic int refCause(input bit p, input int lvl, input bit m,
                                  input bit pe, input bit t, input bit d);
    if (p) return 0;
    if (m  && lvl <= 6) return 1;
    if (pe && lvl <= 5) return 2;
    if (t  && lvl <= 4) return 3;
    if (d  && lvl <= 3) return 4;
    return 0;
  endfunction

  task automatic checkOut();
    total++;
    if (take !== (expCause != 0) || int'(cause) != expCause || errCode !== 8'd0) begin
      bad++;
      $display("FAIL %s: take=%0b cause=%0d err=%0d expected take=%0b cause=%0d err=0",
               tag, take, cause, errCode, expCause != 0, expCause);
    end
  endtask

  // drive at negedge after checking the result of the previous vector (R11)
  task automatic apply(input string t, input bit p, input int lvl,
                       input bit m, input bit pe, input bit tm, input bit d);
    @(negedge clk);
    checkOut();
    tag = t;
    privMode = p; ipl = 3'(lvl);
    reqMachine = m; reqPeer = pe; reqTimer = tm; reqDevice = d;
    expCause = refCause(p, lvl, m, pe, tm, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1"; expCause = 0;
    checkOut();                         // R1 reset state
    rstN = 1'b1;
    apply("R1", 0, 0, 0, 0, 0, 0);
    apply("R3", 0, 2, 0, 0, 0, 1);      // R3 device at low level -> 4
    apply("R4", 0, 4, 0, 0, 0, 1);      // R4 device ignored
    apply("R4", 0, 4, 0, 0, 1, 1);      // R4 timer passes -> 3
    apply("R5", 0, 5, 0, 0, 1, 1);      // R5 timer blocked
    apply("R5", 0, 5, 0, 1, 1, 1);      // R5 peer -> 2
    apply("R6", 0, 6, 0, 1, 1, 1);      // R6 blocked
    apply("R6", 0, 6, 1, 1, 1, 1);      // R6 machine -> 1
    apply("R7", 0, 7, 1, 1, 1, 1);      // R7 nothing
    apply("R2", 1, 0, 1, 1, 1, 1);      // R2 privileged blocks
    apply("R8", 0, 0, 0, 1, 1, 1);      // R8 peer beats timer/device
    apply("R8", 0, 3, 0, 0, 1, 1);      // R8 timer beats device
    apply("R9", 0, 1, 0, 0, 0, 0);      // R9 idle cause 0
    apply("R10", 0, 0, 1, 0, 0, 0);     // R10 error code with take
    for (int v = 0; v < 256; v++) begin // R8 exhaustive sweep
      apply("R8", v[7], int'(v[6:4]), v[3], v[2], v[1], v[0]);
    end
    apply("R11", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    checkOut();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule